// File: doc/BRIEF.md
# Transmit FIFO with Empty-Interrupt Holdoff

This block is the transmit half of a FIFO-mode serial port. It stands between a CPU write port and a transmit shift register. CPU bytes go into a 16-entry queue. The shift register pulls them out through a valid/ready pop handshake as soon as it is able to, so transmission carries on without further CPU action. When the queue holds 16 bytes, new loads are refused. A pop in the same cycle frees a slot, and the load is then accepted.

The block drives a level "transmit queue empty" interrupt, gated by an enable input. There is one exception to the immediate interrupt, and it covers a CPU that is still filling the queue:

- A byte written into an empty queue arms a holdoff.
- If the queue drains while the holdoff is armed, the interrupt is kept low for one character time.
- One character time is `char_ticks` baud ticks, counted from the cycle the queue went empty.
- The holdoff is disarmed once two bytes have been resident together. After that, emptying raises the interrupt at once.

The serial shifter, the baud generator and line framing live outside this block.

Top module: `txq_empty_irq`

## Requirements
- R1: The queue holds at most 16 bytes. With 16 held and `sh_ready` low, `wr_ready` is low and a write is dropped.
- R2: With 16 held, a write in the same cycle as a pop is accepted (`wr_ready` is high while `sh_ready` is high), and occupancy stays at 16.
- R3: Bytes leave in write order. `sh_valid` is high whenever the queue is non-empty, and `sh_data` shows the oldest byte.
- R4: `irq_out` is high exactly when `irq_en` is high, the queue is empty and no holdoff is running. It is low in the cycle after a byte is accepted.
- R5: A byte accepted into an empty queue arms the holdoff. If a pop then empties the queue while the holdoff is armed, `irq_out` stays low until `char_ticks` baud ticks have been seen after the emptying edge, and it rises the cycle after the last of them. A `char_ticks` of 0 counts as 1.
- R6: Once two or more bytes have been resident at the same time, the holdoff is disarmed, and the pop that empties the queue raises `irq_out` in the next cycle.
- R7: A byte written while a holdoff is counting cancels the pending interrupt and re-arms the holdoff. When that byte leaves, a full new character time is counted.
- R8: `fifo_clr` empties the queue and discards any holdoff, taking priority over a write in the same cycle. In the next cycle `sh_valid` is low, `wr_ready` is high, and `irq_out` follows `irq_en`.
- R9: After reset the queue is empty, `wr_ready` is high, and `irq_out` equals `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_clr | input | 1 | Synchronous queue and holdoff clear |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write byte |
| wr_ready | output | 1 | Write will be accepted this cycle |
| sh_ready | input | 1 | Shift register can take a byte |
| sh_valid | output | 1 | Queue holds a byte |
| sh_data | output | 8 | Oldest queued byte |
| baud_tick | input | 1 | One-cycle baud tick |
| char_ticks | input | 8 | Baud ticks per character |
| irq_en | input | 1 | Empty-interrupt enable |
| irq_out | output | 1 | Queue-empty interrupt, level |

## Verification
A wrong occupancy count or pointer shows on the first pop after the fault:

- `sh_data` comes out of order, or
- `sh_valid` or `wr_ready` takes the wrong value, seen by draining the whole queue after every fill.

A holdoff state that is wrong in either direction shows on `irq_out` in the cycle after the emptying pop:

- A missed arming makes the interrupt rise early.
- A missed disarm holds the interrupt low.

A miscounted character timer shows as `irq_out` rising one tick early or late. The bench sweeps several `char_ticks` values so that such an error is caught.

// File: rtl/txq_pkg.sv
// Package: shared types of the transmit queue.
// Assumes nothing beyond IEEE 1800-2017 packages.
package txq_pkg;

    // Holdoff state: idle (interrupt eligible), armed by a single first
    // byte, or waiting out one character time.
    typedef enum logic [1:0] {
        HO_IDLE  = 2'd0,
        HO_ARMED = 2'd1,
        HO_WAIT  = 2'd2
    } ho_state_t;

endpackage

// File: rtl/txq_store.sv
// Module: byte queue storage with pointers and occupancy.
// Does: accepts writes when not full or when a pop frees a slot in the
// same cycle, pops toward the shift register, and reports the
// transitions the holdoff logic needs.
// Assumes: DEPTH >= 2; fifo_clr has priority over writes and pops.
module txq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_rdy,
    output logic              wr_ok,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_fire,
    output logic              pop_fire,
    output logic              into_empty,
    output logic              reach_two,
    output logic              go_empty,
    output logic [CNT_W-1:0]  occ
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  occ_nxt;
    logic              full, empty;

    // Purpose: decode the queue flags and the handshakes.
    always_comb begin
        full     = (occ == CNT_W'(DEPTH));
        empty    = (occ == '0);
        pop_fire = rd_rdy && !empty && !clr;
        wr_ok    = !full || rd_rdy;
        wr_fire  = wr_en && wr_ok && !clr;
        rd_vld   = !empty;
        rd_data  = mem[rptr];
    end

    // Purpose: compute the next occupancy and the transition strobes.
    always_comb begin
        occ_nxt = occ;
        if (wr_fire && !pop_fire) occ_nxt = occ + CNT_W'(1);
        else if (pop_fire && !wr_fire) occ_nxt = occ - CNT_W'(1);
        into_empty = wr_fire && empty;
        reach_two  = (occ_nxt >= CNT_W'(2)) && !clr;
        go_empty   = pop_fire && (occ_nxt == '0);
    end

    // Purpose: store the accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wptr] <= wr_data;
    end

    // Purpose: advance the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (wr_fire) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + PTR_W'(1);
            if (pop_fire) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + PTR_W'(1);
            occ <= occ_nxt;
        end
    end

endmodule

// File: rtl/txq_chartimer.sv
// Module: character-time counter.
// Does: counts baud ticks while running and flags the tick that
// completes one character time (a limit of 0 counts as 1).
// Assumes: start restarts the count; the caller stops run on expiry.
module txq_chartimer #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              tick,
    input  logic [TICK_W-1:0] limit,
    output logic              expire
);

    logic [TICK_W-1:0] cnt;
    logic [TICK_W:0]   lim_eff;
    logic [TICK_W:0]   cnt_inc;

    // Purpose: detect the tick that completes a character.
    always_comb begin
        lim_eff = (limit == '0) ? (TICK_W+1)'(1) : {1'b0, limit};
        cnt_inc = {1'b0, cnt} + (TICK_W+1)'(1);
        expire  = run && tick && (cnt_inc >= lim_eff);
    end

    // Purpose: count ticks while running, restarting on start.
    always_ff @(posedge clk) begin
        if (!rst_n || start) cnt <= '0;
        else if (run && tick) cnt <= cnt + TICK_W'(1);
    end

endmodule

// File: rtl/txq_holdoff.sv
// Module: empty-interrupt holdoff controller.
// Does: arms on a byte into an empty queue, disarms when two bytes are
// resident, and on emptying while armed holds the interrupt off for
// one character time. A write during the wait cancels and re-arms.
// Assumes: strobes come from txq_store in the same cycle.
module txq_holdoff
    import txq_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              into_empty,
    input  logic              reach_two,
    input  logic              go_empty,
    input  logic              tick,
    input  logic [TICK_W-1:0] char_ticks,
    output logic              hold,
    output logic              armed
);

    ho_state_t state, state_nxt;
    logic      t_start, t_expire;

    // Purpose: time one character while waiting.
    txq_chartimer #(.TICK_W(TICK_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (t_start),
        .run    (state == HO_WAIT),
        .tick   (tick),
        .limit  (char_ticks),
        .expire (t_expire)
    );

    // Purpose: next-state logic of the holdoff.
    always_comb begin
        state_nxt = state;
        t_start   = 1'b0;
        unique case (state)
            HO_IDLE:  if (into_empty) state_nxt = HO_ARMED;
            HO_ARMED: begin
                if (reach_two) state_nxt = HO_IDLE;
                else if (go_empty) begin
                    state_nxt = HO_WAIT;
                    t_start   = 1'b1;
                end
            end
            HO_WAIT: begin
                if (into_empty) state_nxt = HO_ARMED;
                else if (t_expire) state_nxt = HO_IDLE;
            end
            default: state_nxt = HO_IDLE;
        endcase
    end

    // Purpose: register the holdoff state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= HO_IDLE;
        else state <= state_nxt;
    end

    assign hold  = (state == HO_WAIT);
    assign armed = (state == HO_ARMED);

endmodule

// File: rtl/txq_empty_irq.sv
// Module: transmit queue with empty interrupt and holdoff (top).
// Does: joins the byte queue and the holdoff controller and gates the
// empty interrupt with the enable.
// Assumes: synchronous active-low reset; baud_tick is a one-cycle pulse.
module txq_empty_irq #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int TICK_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              sh_ready,
    output logic              sh_valid,
    output logic [DATA_W-1:0] sh_data,
    input  logic              baud_tick,
    input  logic [TICK_W-1:0] char_ticks,
    input  logic              irq_en,
    output logic              irq_out
);

    logic             wr_fire, pop_fire, into_empty, reach_two, go_empty;
    logic             hold, armed;
    logic [CNT_W-1:0] occ;

    // Purpose: byte storage and handshakes.
    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_rdy     (sh_ready),
        .wr_ok      (wr_ready),
        .rd_vld     (sh_valid),
        .rd_data    (sh_data),
        .wr_fire    (wr_fire),
        .pop_fire   (pop_fire),
        .into_empty (into_empty),
        .reach_two  (reach_two),
        .go_empty   (go_empty),
        .occ        (occ)
    );

    // Purpose: holdoff sequencing.
    txq_holdoff #(.TICK_W(TICK_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .into_empty (into_empty),
        .reach_two  (reach_two),
        .go_empty   (go_empty),
        .tick       (baud_tick),
        .char_ticks (char_ticks),
        .hold       (hold),
        .armed      (armed)
    );

    // Purpose: gated level interrupt.
    always_comb irq_out = irq_en && (occ == '0) && !hold;

endmodule

// File: rtl/txq_checker.sv
// Module: assertion checker bound to txq_empty_irq.
// Does: checks occupancy bounds, full handling, interrupt and holdoff rules.
// Assumes: bound through the bind statement at the end of this file.
module txq_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_clr,
    input logic             wr_en,
    input logic             irq_en,
    input logic             irq_out,
    input logic             wr_fire,
    input logic             pop_fire,
    input logic             hold,
    input logic             armed,
    input logic [CNT_W-1:0] occ
);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH)); // R1

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && wr_en && !pop_fire) |-> !wr_fire); // R1

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && wr_fire && pop_fire && !fifo_clr) |=> occ == CNT_W'(DEPTH)); // R2

    AST_IRQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (occ == '0 && irq_en)); // R4

    AST_IRQ_DROP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !irq_out); // R4

    AST_HOLD_WHILE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> occ == '0); // R5

    AST_ARMED_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pop_fire && !wr_fire && occ == CNT_W'(1) && !fifo_clr) |=> (hold && !irq_out)); // R5

    AST_DISARMED_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !hold && pop_fire && !wr_fire && occ == CNT_W'(1) && !fifo_clr) |=> !hold); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (occ == '0 && !hold && !armed)); // R8

endmodule

bind txq_empty_irq txq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_clr (fifo_clr),
    .wr_en    (wr_en),
    .irq_en   (irq_en),
    .irq_out  (irq_out),
    .wr_fire  (wr_fire),
    .pop_fire (pop_fire),
    .hold     (hold),
    .armed    (armed),
    .occ      (occ)
);

// File: tb/sim_txq_empty_irq.sv
// Bench: directed sweeps over holdoff lengths, fill/drain and clears.
module sim_txq_empty_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic       sh_ready = 1'b0;
    logic       sh_valid;
    logic [7:0] sh_data;
    logic       baud_tick = 1'b0;
    logic [7:0] char_ticks = 8'd3;
    logic       irq_en = 1'b1;
    logic       irq_out;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    txq_empty_irq u0 (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .sh_ready(sh_ready), .sh_valid(sh_valid), .sh_data(sh_data),
        .baud_tick(baud_tick), .char_ticks(char_ticks),
        .irq_en(irq_en), .irq_out(irq_out)
    );

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b; cyc(); wr_en = 1'b0;
    endtask

    task automatic pop1();
        sh_ready = 1'b1; cyc(); sh_ready = 1'b0;
    endtask

    task automatic tick1();
        baud_tick = 1'b1; cyc(); baud_tick = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk("R9 sh_valid", int'(sh_valid), 0);
        chk("R9 wr_ready", int'(wr_ready), 1);
        chk("R9 irq", int'(irq_out), 1);
        irq_en = 1'b0; #1;
        chk("R4 irq gated off", int'(irq_out), 0);
        irq_en = 1'b1; #1;

        // R5: holdoff sweep over character lengths (0 counts as 1)
        for (int lim = 0; lim <= 4; lim++) begin
            int leff;
            leff = (lim == 0) ? 1 : lim;
            char_ticks = 8'(lim);
            push(8'(8'h40 + lim));
            chk("R4 irq low after load", int'(irq_out), 0);
            chk("R3 head data", int'(sh_data), 8'h40 + lim);
            pop1();
            chk("R3 valid after drain", int'(sh_valid), 0);
            chk("R5 irq held at empty", int'(irq_out), 0);
            for (int k = 1; k <= leff; k++) begin
                cyc();
                chk("R5 idle cycle no tick", int'(irq_out), 0);
                tick1();
                chk("R5 irq after tick", int'(irq_out), (k >= leff) ? 1 : 0);
            end
        end

        // R6: two bytes resident disarms the holdoff
        char_ticks = 8'd3;
        push(8'hA1); push(8'hB2);
        chk("R3 head A", int'(sh_data), 8'hA1);
        pop1();
        chk("R6 one left irq low", int'(irq_out), 0);
        chk("R3 head B", int'(sh_data), 8'hB2);
        pop1();
        chk("R6 irq immediate", int'(irq_out), 1);

        // R7: write during holdoff cancels and restarts
        push(8'h11); pop1();
        tick1();
        chk("R5 held mid window", int'(irq_out), 0);
        push(8'h22);
        chk("R7 irq low after rewrite", int'(irq_out), 0);
        tick1(); tick1();
        chk("R7 no stale expiry", int'(irq_out), 0);
        pop1();
        chk("R7 rearmed hold", int'(irq_out), 0);
        tick1(); tick1();
        chk("R7 still held after 2", int'(irq_out), 0);
        tick1();
        chk("R7 released after full char", int'(irq_out), 1);

        // R1, R2, R3: fill, overflow attempt, swap at full, drain
        for (int i = 0; i < 16; i++) begin
            push(8'(i * 7 + 3));
            chk("R1 wr_ready while filling", int'(wr_ready), (i < 15) ? 1 : 0);
        end
        push(8'hEE);
        chk("R1 head unchanged", int'(sh_data), 3);
        wr_en = 1'b1; wr_data = 8'h5A; sh_ready = 1'b1; #1;
        chk("R2 wr_ready with pop", int'(wr_ready), 1);
        cyc();
        wr_en = 1'b0; sh_ready = 1'b0; #1;
        chk("R2 still full", int'(wr_ready), 0);
        for (int i = 1; i <= 16; i++) begin
            int e;
            e = (i < 16) ? ((i * 7 + 3) & 255) : 8'h5A;
            chk("R3 valid during drain", int'(sh_valid), 1);
            chk("R3 drain order", int'(sh_data), e);
            pop1();
        end
        chk("R3 empty after drain", int'(sh_valid), 0);
        chk("R6 irq after bulk drain", int'(irq_out), 1);

        // R8: clear with contents and a same-cycle write
        push(8'h01); push(8'h02);
        fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h77; cyc();
        fifo_clr = 1'b0; wr_en = 1'b0;
        chk("R8 valid low", int'(sh_valid), 0);
        chk("R8 wr_ready", int'(wr_ready), 1);
        chk("R8 irq", int'(irq_out), 1);
        // R8: clear during a running holdoff
        push(8'h33); pop1();
        chk("R5 held before clear", int'(irq_out), 0);
        fifo_clr = 1'b1; cyc(); fifo_clr = 1'b0;
        chk("R8 irq after clear", int'(irq_out), 1);
        irq_en = 1'b0; #1;
        chk("R8 irq follows enable", int'(irq_out), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule